// File: doc/BRIEF.md
# SPI Register Frame Engine with CRC-8 Protection

This block is the slave end of a 32-bit SPI register access link. A host selects it by pulling the active-low select line, then clocks in one frame in SPI mode 0. The frame carries a 7-bit register address, a direction bit, a 16-bit data word and an 8-bit CRC. While the frame is still arriving, the block looks up the addressed register through a simple register-file port. It then returns a reply on MISO made of a status byte, the register content and a reply CRC.

A write is committed to the register port only after select rises, and only when the frame had exactly 32 clocks and a correct CRC. A frame with the wrong clock count raises a clock-count error pulse. A frame with the right count and a bad CRC raises a CRC error pulse. Neither kind of bad frame writes anything. The serial lines are sampled with the system clock through two-stage synchronizers. SCLK high and low phases must therefore each last at least three system clock cycles.

Top module: `spi_crc_frame`

## Requirements
- R1: A 32-clock frame is decoded as address in bits 31..25, direction in bit 24 and data in bits 23..8, sent MSB first. With direction 1 and a valid CRC, exactly one reg_wr pulse writes the data field to the address when select rises.
- R2: A valid frame with direction 0 is a read. It causes no reg_wr, and MISO bits 23..8 carry the addressed register content.
- R3: The CRC in bits 7..0 is computed MSB first over the 24-bit word of bits 31..8, with polynomial 0x1D and start value 0xFF. A 32-clock frame whose CRC does not match gives one crc_err pulse and no write.
- R4: A frame with a clock count other than 32 gives one clk_err pulse and no write. It gives no crc_err, whatever its content.
- R5: MISO bits 31..24 carry the status_in byte as it was when the frame was selected.
- R6: For a write, MISO bits 23..8 return the register content from before the write.
- R7: MISO bits 7..0 carry a CRC with the same polynomial and start value, computed MSB first over the status byte followed by the 16 returned data bits.
- R8: SPI mode 0 applies. MOSI is sampled on rising SCLK. MISO presents bit 31 after select falls and moves to the next bit after each falling SCLK edge.
- R9: MISO is held low while select is high.
- R10: Each frame produces at most one of reg_wr, crc_err and clk_err, and each one lasts a single clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock (asynchronous) |
| cs_n | input | 1 | SPI select, active low (asynchronous) |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial reply to host |
| status_in | input | 8 | Status byte returned at the head of each reply |
| reg_addr | output | 7 | Register-file address |
| reg_rdata | input | 16 | Register-file read data for reg_addr |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 16 | Register-file write data |
| crc_err | output | 1 | One-cycle pulse: frame CRC mismatch |
| clk_err | output | 1 | One-cycle pulse: frame clock count not 32 |

## Verification
Writes use all-ones, all-zero and mixed data patterns, at the lowest and highest addresses. Each write is followed by a read of the same address, which separates a missing commit from a commit to the wrong place. A pair of writes to one address shows whether the reply returns the old content or the new one. Several status bytes are used, so a reply that mixes up the status, data and CRC fields fails. Corrupted-CRC frames and frames of 31, 33 and 5 clocks check that each fault raises only its own flag and leaves the registers untouched.

// File: rtl/spi_crc_frame.sv
module spi_crc_frame #(
  parameter int DW = 16,
  parameter logic [7:0] POLY = 8'h1D,
  parameter logic [7:0] SEED = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  output logic          miso,
  input  logic [7:0]    status_in,
  output logic [6:0]    reg_addr,
  input  logic [DW-1:0] reg_rdata,
  output logic          reg_wr,
  output logic [DW-1:0] reg_wdata,
  output logic          crc_err,
  output logic          clk_err
);
  localparam int AW   = 7;
  localparam int HDR  = AW + 1;
  localparam int MW   = HDR + DW;
  localparam int FW   = MW + 8;
  localparam int CNTW = $clog2(FW) + 1;
  localparam logic [CNTW-1:0] FULL = CNTW'(FW);
  localparam logic [CNTW-1:0] CMAX = '1;

  function automatic logic [7:0] crc_of(input logic [MW-1:0] w);
    logic [7:0] c;
    logic fb;
    c = SEED;
    for (int i = MW - 1; i >= 0; i--) begin
      fb = c[7] ^ w[i];
      c  = {c[6:0], 1'b0} ^ (fb ? POLY : 8'h00);
    end
    return c;
  endfunction

  logic [2:0] sclk_sr, cs_sr, mosi_sr;
  logic [FW-1:0] rx;
  logic [CNTW-1:0] cnt;
  logic [7:0] status_q, rsp_crc;
  logic [DW-1:0] data_q, wdata_q;
  logic [AW-1:0] addr_q;
  logic load_pend, miso_q;

  wire rise     = sclk_sr[1] & ~sclk_sr[2];
  wire fall     = ~sclk_sr[1] & sclk_sr[2];
  wire cs_act   = ~cs_sr[1];
  wire cs_start = ~cs_sr[1] & cs_sr[2];
  wire cs_end   = cs_sr[1] & ~cs_sr[2];
  wire [7:0] rx_crc = crc_of(rx[FW-1:8]);
  wire [FW-1:0] rsp    = {status_q, data_q, rsp_crc};
  wire [FW-1:0] rsp_sh = rsp << cnt;

  assign miso      = miso_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sr <= '0;
      cs_sr   <= '1;
      mosi_sr <= '0;
    end else begin
      sclk_sr <= {sclk_sr[1:0], sclk};
      cs_sr   <= {cs_sr[1:0], cs_n};
      mosi_sr <= {mosi_sr[1:0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx <= '0; cnt <= '0; status_q <= '0; data_q <= '0; rsp_crc <= '0;
      wdata_q <= '0; addr_q <= '0; load_pend <= 1'b0; miso_q <= 1'b0;
      reg_wr <= 1'b0; crc_err <= 1'b0; clk_err <= 1'b0;
    end else begin
      reg_wr    <= 1'b0;
      crc_err   <= 1'b0;
      clk_err   <= 1'b0;
      load_pend <= 1'b0;
      if (cs_start) begin
        cnt      <= '0;
        status_q <= status_in;
        data_q   <= '0;
        rsp_crc  <= '0;
        miso_q   <= status_in[7];
      end else if (cs_act) begin
        if (rise) begin
          rx <= {rx[FW-2:0], mosi_sr[1]};
          if (cnt != CMAX) cnt <= cnt + 1'b1;
          if (cnt == CNTW'(HDR - 1)) begin
            addr_q    <= rx[AW-1:0];
            load_pend <= 1'b1;
          end
        end
        if (load_pend) begin
          data_q  <= reg_rdata;
          rsp_crc <= crc_of({status_q, reg_rdata});
        end
        if (fall) miso_q <= (cnt < FULL) ? rsp_sh[FW-1] : 1'b0;
      end else begin
        miso_q <= 1'b0;
        if (cs_end) begin
          if (cnt != FULL) clk_err <= 1'b1;
          else if (rx_crc != rx[7:0]) crc_err <= 1'b1;
          else if (rx[FW-HDR]) begin
            reg_wr  <= 1'b1;
            addr_q  <= rx[FW-1:FW-AW];
            wdata_q <= rx[FW-HDR-1:8];
          end
        end
      end
    end
  end

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr); // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({reg_wr, crc_err, clk_err})); // R10
  AST_WR_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr || crc_err) |-> $past(cnt) == FULL); // R4
  AST_IDLE_MISO: assert property (@(posedge clk) disable iff (!rst_n) (cs_sr[1] && cs_sr[2]) |-> !miso); // R9
  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n) cs_start |=> miso == $past(status_in[7])); // R5
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (crc_err || clk_err) |=> !(crc_err || clk_err)); // R10
endmodule

// File: tb/spi_crc_frame_tb_top.sv
module spi_crc_frame_tb_top;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, cs_n = 1, mosi = 0;
  logic miso, reg_wr, crc_err, clk_err;
  logic [7:0] status_in = 8'h00;
  logic [6:0] reg_addr;
  logic [15:0] reg_rdata, reg_wdata;
  logic [15:0] regs [0:127];
  logic [15:0] mdl [0:127];
  int total = 0, bad = 0;
  int n_wr = 0, n_crc = 0, n_clk = 0, idle = 0;
  bit done = 0;
  localparam int HALF = 8;

  always #2.5 clk = ~clk;

  spi_crc_frame dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .status_in(status_in), .reg_addr(reg_addr), .reg_rdata(reg_rdata), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .crc_err(crc_err), .clk_err(clk_err));

  assign reg_rdata = regs[reg_addr];
  always @(posedge clk) if (reg_wr) regs[reg_addr] <= reg_wdata;

  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_wr) n_wr++;
      if (crc_err) n_crc++;
      if (clk_err) n_clk++;
      idle = cs_n ? idle + 1 : 0;
      if (idle > 4 && miso !== 1'b0) begin
        total++; bad++;
        $display("FAIL R9 idle miso actual=%b expected=0", miso);
      end
      if (int'(reg_wr) + int'(crc_err) + int'(clk_err) > 1) begin
        total++; bad++;
        $display("FAIL R10 outcomes actual=%b%b%b expected=at most one", reg_wr, crc_err, clk_err);
      end
    end
  end

  // long division of (message * x^8) by x^8+x^4+x^3+x^2+1, seed folded into top byte
  function automatic logic [7:0] ref_crc(input logic [23:0] msg);
    logic [31:0] m;
    m = {msg ^ 24'hFF0000, 8'h00};
    for (int i = 31; i >= 8; i--)
      if (m[i]) m = m ^ (32'h11D << (i - 8));
    return m[7:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] w, input int nbits, output logic [31:0] rsp);
    rsp = '0;
    @(negedge clk); cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 32) ? w[31 - i] : 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1;
      if (i < 32) rsp[31 - i] = miso;
      repeat (HALF) @(negedge clk);
      sclk = 0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (12) @(negedge clk);
  endtask

  task automatic frame(input string tag, input logic [6:0] a, input bit wr, input logic [15:0] d,
                       input bit badcrc, input int nbits, input logic [7:0] st);
    logic [23:0] body;
    logic [31:0] w, rsp;
    logic [15:0] pre;
    int w0, c0, k0;
    status_in = st;
    body = {a, wr, wr ? d : 16'h0000};
    w = {body, ref_crc(body) ^ (badcrc ? 8'h01 : 8'h00)};
    pre = mdl[a];
    w0 = n_wr; c0 = n_crc; k0 = n_clk;
    xfer(w, nbits, rsp);
    if (nbits == 32) begin
      check({tag, " R5 status"}, {24'h0, rsp[31:24]}, {24'h0, st});
      check({tag, (wr ? " R6 prewrite" : " R2 readdata")}, {16'h0, rsp[23:8]}, {16'h0, pre});
      check({tag, " R7 rspcrc R8"}, {24'h0, rsp[7:0]}, {24'h0, ref_crc({st, pre})});
    end
    check({tag, " R1 wr count"}, n_wr - w0, (nbits == 32 && !badcrc && wr) ? 1 : 0);
    check({tag, " R3 crc_err count"}, n_crc - c0, (nbits == 32 && badcrc) ? 1 : 0);
    check({tag, " R4 clk_err count"}, n_clk - k0, (nbits != 32) ? 1 : 0);
    if (nbits == 32 && !badcrc && wr) mdl[a] = d;
    check({tag, " R1 reg content"}, {16'h0, regs[a]}, {16'h0, mdl[a]});
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      regs[i] = 16'(i * 16'h0101 + 16'h0F0F);
      mdl[i]  = regs[i];
    end
    repeat (5) @(negedge clk);
    check("R9 reset miso", {31'h0, miso}, 0);
    check("R10 reset pulses", {29'h0, reg_wr, crc_err, clk_err}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    frame("rd0",   7'h05, 0, 16'h0000, 0, 32, 8'hA1);
    frame("wrFF",  7'h05, 1, 16'hFFFF, 0, 32, 8'h3C);
    frame("wr00",  7'h05, 1, 16'h0000, 0, 32, 8'hFF);
    frame("rd05",  7'h05, 0, 16'h0000, 0, 32, 8'h00);
    frame("wrmax", 7'h7F, 1, 16'hA5C3, 0, 32, 8'h81);
    frame("wrmin", 7'h00, 1, 16'h5A3C, 0, 32, 8'h7E);
    frame("rdmax", 7'h7F, 0, 16'h0000, 0, 32, 8'h12);
    frame("rdmin", 7'h00, 0, 16'h0000, 0, 32, 8'hC4);
    frame("badcrc", 7'h22, 1, 16'h1234, 1, 32, 8'h55);
    frame("rd22",  7'h22, 0, 16'h0000, 0, 32, 8'h55);
    frame("short", 7'h22, 1, 16'h4321, 0, 31, 8'h66);
    frame("long",  7'h22, 1, 16'h4321, 0, 33, 8'h66);
    frame("tiny",  7'h22, 1, 16'h4321, 0, 5,  8'h66);
    frame("rd22b", 7'h22, 0, 16'h0000, 0, 32, 8'h99);
    frame("wr22",  7'h22, 1, 16'hBEEF, 0, 32, 8'h0A);
    frame("rdbad", 7'h22, 0, 16'h0000, 1, 32, 8'h0B);
    frame("rd22c", 7'h22, 0, 16'h0000, 0, 32, 8'h0C);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule